// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Peripheral Overrides

This block controls a bank of general-purpose pins. Each pin has a direction bit and an output bit. The output bit also serves as the pull-up request while the pin is an input. A two-flop synchronizer brings the pad level back to the register bus. Peripheral modules elsewhere on the chip can take over five aspects of any pin through per-pin enable/value pairs: the pull-up, the driver enable, the driven value, the digital input enable, and a per-cycle inversion of the output bit. An override always wins over the register setting it replaces.

Software reaches the port through three register addresses: direction, output and pin. Each address has its own write strobe and read strobe, and all pins share them. A write to the pin address flips the output bits selected by the ones in the data. A sleep input turns the digital inputs off unless a peripheral overrides it. A global pull-up disable suppresses every pull-up that comes from the registers. Peripherals also get an unsynchronized, gated copy of each pad input. Pins marked as dedicated reset inputs read back 0 at all three addresses.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction and output registers hold 0, so every pad driver enable, driven value and pull-up is 0, and the direction and output addresses read 0.
- R2: With the pull-up override enable at 0, a pin's pull-up is 1 only when its direction bit is 0, its output bit is 1 and the global pull-up disable is 0.
- R3: With the pull-up override enable at 1, the pull-up equals the pull-up override value, whatever the direction bit, output bit and global disable are.
- R4: The pad driver enable equals the direction override value when the direction override enable is 1, and the direction register bit otherwise.
- R5: While the driver is enabled, the pad value is the value override bit if the value override enable is 1, and the output register bit otherwise. While the driver is disabled, the pad value is 0.
- R6: On every clock edge where a pin's toggle override enable is 1, that pin's output register bit is inverted. The inversion is applied on top of any bus write in the same cycle.
- R7: A write to the pin address inverts each output bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R8: The digital input enable equals the input-enable override value when that override enable is 1. Otherwise it is 0 while sleep is 1 and 1 while sleep is 0. A disabled input forces both the raw tap and the synchronizer input to 0.
- R9: The raw input tap follows the gated pad input in the same cycle. The pin address returns the gated pad input as it stood two rising clock edges earlier.
- R10: The read data is the direction register when the direction read strobe is 1. Otherwise it is the output register when the output read strobe is 1, then the synchronized pins when the pin read strobe is 1. With no read strobe it is 0.
- R11: A bit set in the reset-pin select reads 0 at the direction, output and pin addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wdata_i | input | 8 | Register write data |
| dir_wr_i | input | 1 | Write strobe, direction address |
| out_wr_i | input | 1 | Write strobe, output address |
| pin_wr_i | input | 1 | Write strobe, pin address (toggle) |
| dir_rd_i | input | 1 | Read strobe, direction address |
| out_rd_i | input | 1 | Read strobe, output address |
| pin_rd_i | input | 1 | Read strobe, pin address |
| bus_rdata_o | output | 8 | Read data |
| pu_ovr_en_i | input | 8 | Pull-up override enable per pin |
| pu_ovr_val_i | input | 8 | Pull-up override value per pin |
| dir_ovr_en_i | input | 8 | Driver enable override enable per pin |
| dir_ovr_val_i | input | 8 | Driver enable override value per pin |
| val_ovr_en_i | input | 8 | Driven value override enable per pin |
| val_ovr_val_i | input | 8 | Driven value override value per pin |
| tgl_ovr_en_i | input | 8 | Output bit toggle override per pin |
| ie_ovr_en_i | input | 8 | Input enable override enable per pin |
| ie_ovr_val_i | input | 8 | Input enable override value per pin |
| sleep_i | input | 1 | Sleep control, shared |
| pu_dis_i | input | 1 | Global pull-up disable, shared |
| rst_pin_sel_i | input | 8 | Pins acting as dedicated reset inputs |
| pad_in_i | input | 8 | Raw pad input levels |
| pad_oe_o | output | 8 | Pad driver enable |
| pad_out_o | output | 8 | Pad driven value |
| pad_pu_o | output | 8 | Pad pull-up enable |
| pad_ie_o | output | 8 | Pad digital input enable |
| raw_in_o | output | 8 | Unsynchronized gated input for peripherals |

## Verification
The bench targets the points where an override and a register bit meet. A pull-up must still follow the direction register when only the driver is overridden, so a design that used the overridden driver enable would drop that pull-up. A pad that is not driven must hold value 0 even when the value override is set, and a design that got this wrong would leak the override value onto an input pin. The bench counts the synchronizer latency edge by edge: a design with one stage too few or too many returns the new pin value one cycle early or late. It also checks that sleep blanks the raw tap and that an input-enable override reopens it. Finally, it checks that toggle writes flip only the selected bits, and that reset-pin bits read 0 even after software has set them to 1.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_DIR  = 2'd1,
        RD_OUT  = 2'd2,
        RD_PIN  = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] wdata_i,
    input  logic         dir_wr_i,
    input  logic         out_wr_i,
    input  logic         pin_wr_i,
    input  logic [W-1:0] tgl_en_i,
    output logic [W-1:0] dir_q_o,
    output logic [W-1:0] out_q_o
);
    logic [W-1:0] out_base;
    logic [W-1:0] out_nxt;

    always_comb begin
        out_base = out_wr_i ? wdata_i : out_q_o;
        out_nxt  = out_base ^ (pin_wr_i ? wdata_i : '0) ^ tgl_en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dir_q_o <= '0;
            out_q_o <= '0;
        end else begin
            if (dir_wr_i) begin
                dir_q_o <= wdata_i;
            end
            out_q_o <= out_nxt;
        end
    end

    AST_TGL_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!out_wr_i && !pin_wr_i) |=> ((out_q_o ^ $past(out_q_o)) == $past(tgl_en_i))); // R6

    AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dir_wr_i |=> $stable(dir_q_o)); // R4
endmodule

// File: rtl/gpio_ovr_pin.sv
module gpio_ovr_pin (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dir_q_i,
    input  logic out_q_i,
    input  logic pu_dis_i,
    input  logic sleep_i,
    input  logic pu_ovr_en_i,
    input  logic pu_ovr_val_i,
    input  logic dir_ovr_en_i,
    input  logic dir_ovr_val_i,
    input  logic val_ovr_en_i,
    input  logic val_ovr_val_i,
    input  logic ie_ovr_en_i,
    input  logic ie_ovr_val_i,
    input  logic pad_in_i,
    output logic pad_oe_o,
    output logic pad_out_o,
    output logic pad_pu_o,
    output logic pad_ie_o,
    output logic din_o
);
    logic reg_pu;

    always_comb begin
        reg_pu    = !dir_q_i && out_q_i && !pu_dis_i;
        pad_pu_o  = pu_ovr_en_i ? pu_ovr_val_i : reg_pu;
        pad_oe_o  = dir_ovr_en_i ? dir_ovr_val_i : dir_q_i;
        pad_out_o = pad_oe_o && (val_ovr_en_i ? val_ovr_val_i : out_q_i);
        pad_ie_o  = ie_ovr_en_i ? ie_ovr_val_i : !sleep_i;
        din_o     = pad_in_i && pad_ie_o;
    end

    AST_PU_NOT_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pad_pu_o && !pu_ovr_en_i && !dir_ovr_en_i) |-> !pad_oe_o); // R2

    AST_SLEEP_IE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sleep_i && !ie_ovr_en_i) |-> (!pad_ie_o && !din_o)); // R8

    AST_IDLE_PAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pad_oe_o |-> !pad_out_o); // R5
endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    import gpio_ovr_pkg::*;

    logic [W-1:0] stage [SYNC_STAGES];

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    stage[s] <= '0;
                end else begin
                    stage[s] <= (s == 0) ? d_i : stage[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage[SYNC_STAGES-1];

    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            warm_q <= '0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm_q == 2'd2) |-> (q_o == $past(d_i, 2))); // R9
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] bus_wdata_i,
    input  logic             dir_wr_i,
    input  logic             out_wr_i,
    input  logic             pin_wr_i,
    input  logic             dir_rd_i,
    input  logic             out_rd_i,
    input  logic             pin_rd_i,
    output logic [WIDTH-1:0] bus_rdata_o,
    input  logic [WIDTH-1:0] pu_ovr_en_i,
    input  logic [WIDTH-1:0] pu_ovr_val_i,
    input  logic [WIDTH-1:0] dir_ovr_en_i,
    input  logic [WIDTH-1:0] dir_ovr_val_i,
    input  logic [WIDTH-1:0] val_ovr_en_i,
    input  logic [WIDTH-1:0] val_ovr_val_i,
    input  logic [WIDTH-1:0] tgl_ovr_en_i,
    input  logic [WIDTH-1:0] ie_ovr_en_i,
    input  logic [WIDTH-1:0] ie_ovr_val_i,
    input  logic             sleep_i,
    input  logic             pu_dis_i,
    input  logic [WIDTH-1:0] rst_pin_sel_i,
    input  logic [WIDTH-1:0] pad_in_i,
    output logic [WIDTH-1:0] pad_oe_o,
    output logic [WIDTH-1:0] pad_out_o,
    output logic [WIDTH-1:0] pad_pu_o,
    output logic [WIDTH-1:0] pad_ie_o,
    output logic [WIDTH-1:0] raw_in_o
);
    import gpio_ovr_pkg::*;

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] pin_q;
    logic [WIDTH-1:0] rd_raw;
    rd_sel_e          rd_sel;

    gpio_ovr_regs #(.W(WIDTH)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wdata_i  (bus_wdata_i),
        .dir_wr_i (dir_wr_i),
        .out_wr_i (out_wr_i),
        .pin_wr_i (pin_wr_i),
        .tgl_en_i (tgl_ovr_en_i),
        .dir_q_o  (dir_q),
        .out_q_o  (out_q)
    );

    generate
        for (genvar p = 0; p < WIDTH; p++) begin : g_pin
            gpio_ovr_pin u_pin (
                .clk_i         (clk_i),
                .rst_ni        (rst_ni),
                .dir_q_i       (dir_q[p]),
                .out_q_i       (out_q[p]),
                .pu_dis_i      (pu_dis_i),
                .sleep_i       (sleep_i),
                .pu_ovr_en_i   (pu_ovr_en_i[p]),
                .pu_ovr_val_i  (pu_ovr_val_i[p]),
                .dir_ovr_en_i  (dir_ovr_en_i[p]),
                .dir_ovr_val_i (dir_ovr_val_i[p]),
                .val_ovr_en_i  (val_ovr_en_i[p]),
                .val_ovr_val_i (val_ovr_val_i[p]),
                .ie_ovr_en_i   (ie_ovr_en_i[p]),
                .ie_ovr_val_i  (ie_ovr_val_i[p]),
                .pad_in_i      (pad_in_i[p]),
                .pad_oe_o      (pad_oe_o[p]),
                .pad_out_o     (pad_out_o[p]),
                .pad_pu_o      (pad_pu_o[p]),
                .pad_ie_o      (pad_ie_o[p]),
                .din_o         (raw_in_o[p])
            );
        end
    endgenerate

    gpio_ovr_sync #(.W(WIDTH)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_in_o),
        .q_o    (pin_q)
    );

    always_comb begin
        if (dir_rd_i) begin
            rd_sel = RD_DIR;
        end else if (out_rd_i) begin
            rd_sel = RD_OUT;
        end else if (pin_rd_i) begin
            rd_sel = RD_PIN;
        end else begin
            rd_sel = RD_NONE;
        end
    end

    always_comb begin
        unique case (rd_sel)
            RD_DIR:  rd_raw = dir_q;
            RD_OUT:  rd_raw = out_q;
            RD_PIN:  rd_raw = pin_q;
            default: rd_raw = '0;
        endcase
        bus_rdata_o = rd_raw & ~rst_pin_sel_i;
    end

    AST_RST_PIN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rdata_o & rst_pin_sel_i) == '0); // R11

    AST_NO_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dir_rd_i && !out_rd_i && !pin_rd_i) |-> (bus_rdata_o == '0)); // R10
endmodule

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wdata = '0;
    logic       dir_wr = 0, out_wr = 0, pin_wr = 0;
    logic       dir_rd = 0, out_rd = 0, pin_rd = 0;
    logic [7:0] rdata;
    logic [7:0] pu_en = '0, pu_val = '0, dr_en = '0, dr_val = '0;
    logic [7:0] vl_en = '0, vl_val = '0, tg_en = '0, ie_en = '0, ie_val = '0;
    logic       sleep = 0, pu_dis = 0;
    logic [7:0] rst_sel = '0, pad_in = '0;
    logic [7:0] oe, pout, pu, ie, raw;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpio_ovr_port dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_wdata_i(wdata),
        .dir_wr_i(dir_wr), .out_wr_i(out_wr), .pin_wr_i(pin_wr),
        .dir_rd_i(dir_rd), .out_rd_i(out_rd), .pin_rd_i(pin_rd),
        .bus_rdata_o(rdata),
        .pu_ovr_en_i(pu_en), .pu_ovr_val_i(pu_val),
        .dir_ovr_en_i(dr_en), .dir_ovr_val_i(dr_val),
        .val_ovr_en_i(vl_en), .val_ovr_val_i(vl_val),
        .tgl_ovr_en_i(tg_en), .ie_ovr_en_i(ie_en), .ie_ovr_val_i(ie_val),
        .sleep_i(sleep), .pu_dis_i(pu_dis), .rst_pin_sel_i(rst_sel),
        .pad_in_i(pad_in), .pad_oe_o(oe), .pad_out_o(pout), .pad_pu_o(pu),
        .pad_ie_o(ie), .raw_in_o(raw)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // write on one edge; caller is at a negedge
    task automatic wr(input int which, input logic [7:0] d);
        wdata = d;
        dir_wr = (which == 0);
        out_wr = (which == 1);
        pin_wr = (which == 2);
        @(posedge clk);
        @(negedge clk);
        dir_wr = 0; out_wr = 0; pin_wr = 0;
    endtask

    task automatic rd(input int which, output logic [7:0] d);
        dir_rd = (which == 0);
        out_rd = (which == 1);
        pin_rd = (which == 2);
        #1;
        d = rdata;
        dir_rd = 0; out_rd = 0; pin_rd = 0;
        #1;
    endtask

    // {dir, out, pu_dis, pu_en, pu_val, dr_en, dr_val, vl_en, vl_val, exp_oe, exp_out, exp_pu}
    localparam logic [11:0] VEC [12] = '{
        12'b000_00_00_00_000,  // R1/R2 all off
        12'b010_00_00_00_001,  // R2 pull-up on
        12'b011_00_00_00_000,  // R2 disabled globally
        12'b110_00_00_00_110,  // R5 drive port bit 1
        12'b100_00_00_00_100,  // R5 drive port bit 0
        12'b000_11_00_00_001,  // R3 forced on
        12'b010_10_00_00_000,  // R3 forced off
        12'b010_00_11_00_111,  // R4 driver forced, pull-up from registers
        12'b110_00_10_00_000,  // R4 driver forced off
        12'b100_00_00_11_110,  // R5 value override 1
        12'b110_00_00_10_100,  // R5 value override 0
        12'b000_00_00_11_000   // R5 not driving, pad low
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state while reset still asserted
        chk("R1 oe", oe, 8'h00);
        chk("R1 pu", pu, 8'h00);
        rst_n = 1;
        @(negedge clk);
        rd(0, d); chk("R1 dir read", d, 8'h00);
        rd(1, d); chk("R1 out read", d, 8'h00);

        foreach (VEC[i]) begin
            logic [11:0] v;
            v = VEC[i];
            wr(0, {8{v[11]}});
            wr(1, {8{v[10]}});
            pu_dis = v[9];
            pu_en  = {8{v[8]}};
            pu_val = {8{v[7]}};
            dr_en  = {8{v[6]}};
            dr_val = {8{v[5]}};
            vl_en  = {8{v[4]}};
            vl_val = {8{v[3]}};
            #1;
            chk($sformatf("R2-vec%0d oe", i),  oe,   {8{v[2]}});
            chk($sformatf("R5-vec%0d out", i), pout, {8{v[1]}});
            chk($sformatf("R3-vec%0d pu", i),  pu,   {8{v[0]}});
            @(negedge clk);
        end
        pu_dis = 0; pu_en = '0; pu_val = '0; dr_en = '0; dr_val = '0;
        vl_en = '0; vl_val = '0;

        // R6 toggle override for one edge
        wr(1, 8'h00);
        tg_en = 8'h05;
        @(posedge clk); @(negedge clk);
        tg_en = 8'h00;
        rd(1, d); chk("R6 toggle once", d, 8'h05);
        // R6 toggle on top of a bus write
        tg_en = 8'h01;
        wr(1, 8'hF0);
        tg_en = 8'h00;
        rd(1, d); chk("R6 toggle with write", d, 8'hF1);

        // R7 pin-address write flips selected bits
        wr(1, 8'h0F);
        wr(2, 8'h81);
        rd(1, d); chk("R7 pin write toggle", d, 8'h8E);
        wr(2, 8'h00);
        rd(1, d); chk("R7 zero write no effect", d, 8'h8E);

        // R8 sleep blanks inputs, override reopens
        wr(0, 8'h00);
        pad_in = 8'hFF;
        sleep = 1;
        #1;
        chk("R8 sleep ie", ie, 8'h00);
        chk("R8 sleep raw", raw, 8'h00);
        ie_en = 8'hFF; ie_val = 8'h0F;
        #1;
        chk("R8 override raw", raw, 8'h0F);
        @(negedge clk); @(negedge clk);
        rd(2, d); chk("R8 gated pin read", d, 8'h0F);
        ie_en = '0; ie_val = '0; sleep = 0;

        // R9 latency: raw same cycle, pin after two edges
        pad_in = 8'h00;
        @(negedge clk); @(negedge clk); @(negedge clk);
        pad_in = 8'hA5;
        #1;
        chk("R9 raw same cycle", raw, 8'hA5);
        @(negedge clk);
        rd(2, d); chk("R9 pin after one edge", d, 8'h00);
        @(negedge clk);
        rd(2, d); chk("R9 pin after two edges", d, 8'hA5);

        // R10 read priority and idle
        wr(0, 8'h3C);
        wr(1, 8'hC3);
        dir_rd = 1; out_rd = 1; pin_rd = 1; #1;
        chk("R10 dir priority", rdata, 8'h3C);
        dir_rd = 0; #1;
        chk("R10 out priority", rdata, 8'hC3);
        out_rd = 0; pin_rd = 0; #1;
        chk("R10 idle zero", rdata, 8'h00);

        // R11 reset pin reads 0
        rst_sel = 8'h80;
        wr(0, 8'hFF);
        wr(1, 8'hFF);
        pad_in = 8'hFF;
        @(negedge clk); @(negedge clk);
        rd(0, d); chk("R11 dir masked", d, 8'h7F);
        rd(1, d); chk("R11 out masked", d, 8'h7F);
        rd(2, d); chk("R11 pin masked", d, 8'h7F);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule